// File: doc/BRIEF.md
# Memory Wait-State Controller with Violation Lockout

This block decides how many wait states each access to a slow nonvolatile memory receives, and it runs the wait counter that paces each access. Software programs a mode bit, a 4-bit wait field, a write-protect bit and an interrupt enable through a single register write strobe. In user mode the wait field is used as written. In automatic mode the block picks the count from a 2-bit clock-range input. In debug mode no wait states are inserted at all.

A timing-violation input starts a lockout. The block latches a sticky error flag, forces the effective wait count to its maximum, blocks memory writes and pulses a cache-flush output. The lockout holds until software writes the clear bit. The stored wait field and write-protect bit are never altered by the lockout, so the programmed values take effect again once the flag is cleared. The flag can drive a non-maskable interrupt request when the interrupt enable is set.

Top module: `memwait_ctrl`

## Requirements
- R1: After reset the block is in user mode with a wait field of 0, write-protect set, the interrupt enable clear and the error flag clear, so `wr_en_o`, `nmi_o`, `flush_o` and `err_flag_o` are 0 and `wait_eff_o` is 0.
- R2: In user mode (`cfg_auto_i` written 0), with the flag clear and debug low, `wait_eff_o` equals the stored wait field.
- R3: When `acc_req_i` is high in a cycle where no access is in progress, the current `wait_eff_o` value N is captured. `acc_rdy_o` rises N cycles later, or in the same cycle when N is 0. The requester holds `acc_req_i` high until it sees ready.
- R4: A cycle with `viol_i` high sets the error flag at the next edge and gives a one-cycle high on `flush_o` in the following cycle. While the flag is set and debug is low, `wait_eff_o` is 15.
- R5: `wr_en_o` is 1 only when the error flag is clear and write-protect is clear.
- R6: Register writes during lockout are stored. Once the flag clears, `wait_eff_o` follows the stored wait field again.
- R7: `nmi_o` is high exactly when the error flag is set and the stored interrupt enable is 1.
- R8: In automatic mode with the flag clear and debug low, the wait field is ignored. `wait_eff_o` is 3 for clock-range codes 0, 1 and 2, and 4 for code 3.
- R9: While `dbg_i` is high, `wait_eff_o` is 0 whatever the mode, the wait field or the error flag.
- R10: A register write with `cfg_clr_i` high in the same cycle as `viol_i` leaves the error flag set.
- R11: The error flag is cleared only by a register write with `cfg_clr_i` high. A write with `cfg_clr_i` low leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe, loads all configuration fields |
| cfg_auto_i | input | 1 | Automatic wait mode when 1 |
| cfg_wait_i | input | 4 | Programmed wait count for user mode |
| cfg_wprot_i | input | 1 | Write-protect bit |
| cfg_nmi_en_i | input | 1 | Interrupt enable for the error flag |
| cfg_clr_i | input | 1 | Writing 1 with the strobe clears the error flag |
| viol_i | input | 1 | Timing-violation event |
| dbg_i | input | 1 | Debug mode, removes all wait states |
| clk_range_i | input | 2 | System clock range code for automatic mode |
| acc_req_i | input | 1 | Memory access request |
| acc_rdy_o | output | 1 | Access completes in this cycle |
| wait_eff_o | output | 4 | Effective wait count applied now |
| wr_en_o | output | 1 | Memory write permitted |
| flush_o | output | 1 | Cache flush pulse |
| nmi_o | output | 1 | Non-maskable interrupt request |
| err_flag_o | output | 1 | Sticky access-time error flag |

## Verification
The effective wait count, write enable and interrupt request follow the stored state combinationally. They therefore change in the cycle right after the edge that takes a register write or a violation. The flush pulse appears in that same cycle and lasts exactly one cycle. Ready comes N cycles after the request cycle, or in that cycle itself when N is 0. Inputs change just after each rising edge, and all outputs are compared at the falling edge against a behavioural model that advances on the rising edge. Directed checks measure access latency in cycles, counting from the request cycle.

// File: rtl/mwc_pkg.sv
package mwc_pkg;
  localparam int unsigned WAIT_W = 4;
  typedef logic [WAIT_W-1:0] wait_t;

  typedef struct packed {
    logic  auto_mode;
    wait_t wait_n;
    logic  wprot;
    logic  nmi_en;
  } mwc_cfg_t;

  typedef enum logic {
    CNT_IDLE = 1'b0,
    CNT_BUSY = 1'b1
  } cnt_state_e;
endpackage

// File: rtl/mwc_regs.sv
module mwc_regs
  import mwc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_stb,
  input  mwc_cfg_t wr_cfg,
  input  logic     wr_clr,
  input  logic     viol,
  output mwc_cfg_t cfg_o,
  output logic     flag_o,
  output logic     flush_o,
  output logic     wr_en_o,
  output logic     nmi_o
);
  mwc_cfg_t cfg_q, cfg_d;
  logic     flag_q, flag_d;
  logic     flush_q, flush_d;

  always_comb begin
    cfg_d   = cfg_q;
    flag_d  = flag_q;
    flush_d = viol;
    if (wr_stb) cfg_d = wr_cfg;
    if (viol)
      flag_d = 1'b1;
    else if (wr_stb && wr_clr)
      flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.auto_mode <= 1'b0;
      cfg_q.wait_n    <= '0;
      cfg_q.wprot     <= 1'b1;
      cfg_q.nmi_en    <= 1'b0;
      flag_q          <= 1'b0;
      flush_q         <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      flag_q  <= flag_d;
      flush_q <= flush_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign flag_o  = flag_q;
  assign flush_o = flush_q;
  assign wr_en_o = !cfg_q.wprot && !flag_q;
  assign nmi_o   = flag_q && cfg_q.nmi_en;

  // R10
  viol_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> flag_o);
  // R4
  viol_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> flush_o);
  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !(wr_stb && wr_clr)) |=> flag_o);
  // R5
  locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |-> !wr_en_o);
  // R7
  nmi_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |-> flag_o);
endmodule

// File: rtl/mwc_sel.sv
module mwc_sel
  import mwc_pkg::*;
#(
  parameter int unsigned RANGE_W   = 2,
  parameter int unsigned AUTO_SLOW = 3,
  parameter int unsigned AUTO_FAST = 4
) (
  input  logic               auto_mode,
  input  wait_t              wait_n,
  input  logic               flag,
  input  logic               dbg,
  input  logic [RANGE_W-1:0] rng,
  output wait_t              wait_eff
);
  localparam int unsigned RANGES = 2 ** RANGE_W;
  localparam wait_t       MAX_WAIT = '1;

  wait_t auto_tbl [RANGES];

  for (genvar r = 0; r < RANGES; r++) begin : g_tbl
    if (r == RANGES - 1) begin : g_fast
      assign auto_tbl[r] = wait_t'(AUTO_FAST);
    end else begin : g_slow
      assign auto_tbl[r] = wait_t'(AUTO_SLOW);
    end
  end

  always_comb begin
    if (dbg)
      wait_eff = '0;
    else if (flag)
      wait_eff = MAX_WAIT;
    else if (auto_mode)
      wait_eff = auto_tbl[rng];
    else
      wait_eff = wait_n;
  end
endmodule

// File: rtl/mwc_cnt.sv
module mwc_cnt
  import mwc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  wait_t wait_eff,
  output logic  rdy
);
  cnt_state_e state_q, state_d;
  wait_t      cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rdy     = 1'b0;
    case (state_q)
      CNT_IDLE: begin
        if (req) begin
          if (wait_eff == '0) begin
            rdy = 1'b1;
          end else begin
            state_d = CNT_BUSY;
            cnt_d   = wait_eff;
          end
        end
      end
      default: begin
        if (cnt_q == wait_t'(1)) begin
          rdy     = 1'b1;
          state_d = CNT_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - wait_t'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CNT_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3
  busy_count_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CNT_BUSY) |-> (cnt_q != '0));
  // R3
  done_returns_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == CNT_BUSY && rdy) |=> (state_q == CNT_IDLE));
endmodule

// File: rtl/memwait_ctrl.sv
module memwait_ctrl
  import mwc_pkg::*;
#(
  parameter int unsigned RANGE_W   = 2,
  parameter int unsigned AUTO_SLOW = 3,
  parameter int unsigned AUTO_FAST = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_i,
  input  logic               cfg_auto_i,
  input  logic [WAIT_W-1:0]  cfg_wait_i,
  input  logic               cfg_wprot_i,
  input  logic               cfg_nmi_en_i,
  input  logic               cfg_clr_i,
  input  logic               viol_i,
  input  logic               dbg_i,
  input  logic [RANGE_W-1:0] clk_range_i,
  input  logic               acc_req_i,
  output logic               acc_rdy_o,
  output logic [WAIT_W-1:0]  wait_eff_o,
  output logic               wr_en_o,
  output logic               flush_o,
  output logic               nmi_o,
  output logic               err_flag_o
);
  mwc_cfg_t wr_cfg;
  mwc_cfg_t cfg;
  logic     flag;
  wait_t    wait_eff;

  assign wr_cfg.auto_mode = cfg_auto_i;
  assign wr_cfg.wait_n    = cfg_wait_i;
  assign wr_cfg.wprot     = cfg_wprot_i;
  assign wr_cfg.nmi_en    = cfg_nmi_en_i;

  mwc_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_stb  (cfg_wr_i),
    .wr_cfg  (wr_cfg),
    .wr_clr  (cfg_clr_i),
    .viol    (viol_i),
    .cfg_o   (cfg),
    .flag_o  (flag),
    .flush_o (flush_o),
    .wr_en_o (wr_en_o),
    .nmi_o   (nmi_o)
  );

  mwc_sel #(
    .RANGE_W   (RANGE_W),
    .AUTO_SLOW (AUTO_SLOW),
    .AUTO_FAST (AUTO_FAST)
  ) u_sel (
    .auto_mode (cfg.auto_mode),
    .wait_n    (cfg.wait_n),
    .flag      (flag),
    .dbg       (dbg_i),
    .rng       (clk_range_i),
    .wait_eff  (wait_eff)
  );

  mwc_cnt u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (acc_req_i),
    .wait_eff (wait_eff),
    .rdy      (acc_rdy_o)
  );

  assign wait_eff_o = wait_eff;
  assign err_flag_o = flag;

  // R9
  debug_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_i |-> (wait_eff_o == '0));
  // R4
  lockout_max_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag_o && !dbg_i) |-> (wait_eff_o == '1));
  // R8
  auto_fast_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_i && !err_flag_o && cfg.auto_mode && clk_range_i == '1)
      |-> (wait_eff_o == wait_t'(AUTO_FAST)));
endmodule

// File: tb/memwait_ctrl_tb_top.sv
`timescale 1ns/1ps
module memwait_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_wr, cfg_auto, cfg_wprot, cfg_nmi_en, cfg_clr;
  logic [3:0] cfg_wait;
  logic       viol, dbg, acc_req;
  logic [1:0] rng;
  logic       acc_rdy, wr_en, flush, nmi, err_flag;
  logic [3:0] wait_eff;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  memwait_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_i(cfg_wr), .cfg_auto_i(cfg_auto),
    .cfg_wait_i(cfg_wait), .cfg_wprot_i(cfg_wprot), .cfg_nmi_en_i(cfg_nmi_en),
    .cfg_clr_i(cfg_clr), .viol_i(viol), .dbg_i(dbg), .clk_range_i(rng),
    .acc_req_i(acc_req), .acc_rdy_o(acc_rdy), .wait_eff_o(wait_eff),
    .wr_en_o(wr_en), .flush_o(flush), .nmi_o(nmi), .err_flag_o(err_flag)
  );

  // behavioural reference state
  bit m_auto, m_wprot, m_ien, m_flag, m_flush, m_busy;
  int m_wait, m_left;

  function automatic int m_eff();
    if (dbg) return 0;
    if (m_flag) return 15;
    if (m_auto) return (rng == 2'd3) ? 4 : 3;
    return m_wait;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_auto = 0; m_wait = 0; m_wprot = 1; m_ien = 0;
      m_flag = 0; m_flush = 0; m_busy = 0; m_left = 0;
    end else begin
      int e;
      e = m_eff();
      if (!m_busy) begin
        if (acc_req && e != 0) begin m_busy = 1; m_left = e; end
      end else if (m_left == 1) begin
        m_busy = 0;
      end else begin
        m_left = m_left - 1;
      end
      m_flush = viol;
      if (viol) m_flag = 1;
      else if (cfg_wr && cfg_clr) m_flag = 0;
      if (cfg_wr) begin
        m_auto = cfg_auto; m_wait = cfg_wait; m_wprot = cfg_wprot; m_ien = cfg_nmi_en;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !done) begin
      int er;
      er = m_busy ? (m_left == 1) : (acc_req && m_eff() == 0);
      check("R2 wait_eff vs model", wait_eff, m_eff());
      check("R3 acc_rdy vs model", acc_rdy, er);
      check("R5 wr_en vs model", wr_en, !m_wprot && !m_flag);
      check("R7 nmi vs model", nmi, m_flag && m_ien);
      check("R4 flush vs model", flush, m_flush);
      check("R10 flag vs model", err_flag, m_flag);
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cfg_write(bit a, int w, bit p, bit ie, bit c);
    cfg_wr = 1; cfg_auto = a; cfg_wait = w[3:0]; cfg_wprot = p; cfg_nmi_en = ie; cfg_clr = c;
    tick();
    cfg_wr = 0; cfg_clr = 0;
  endtask

  task automatic access(string tag, int exp_lat);
    int n = 0;
    acc_req = 1;
    forever begin
      @(negedge clk);
      if (acc_rdy) break;
      n++;
      if (n > 40) break;
    end
    check(tag, n, exp_lat);
    tick();
    acc_req = 0;
  endtask

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_auto = 0; cfg_wait = 0; cfg_wprot = 0;
    cfg_nmi_en = 0; cfg_clr = 0; viol = 0; dbg = 0; rng = 0; acc_req = 0;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    check("R1 reset wr_en", wr_en, 0);
    check("R1 reset nmi", nmi, 0);
    check("R1 reset flag", err_flag, 0);
    check("R1 reset flush", flush, 0);
    check("R1 reset wait", wait_eff, 0);
    tick();
    access("R3 zero-wait latency", 0);

    cfg_write(0, 5, 0, 0, 0);
    @(negedge clk);
    check("R2 user wait 5", wait_eff, 5);
    check("R5 unprotected write enable", wr_en, 1);
    tick();
    access("R3 five-wait latency", 5);

    cfg_write(1, 9, 0, 0, 0);
    rng = 0; @(negedge clk); check("R8 auto range0", wait_eff, 3);
    tick(); rng = 2; @(negedge clk); check("R8 auto range2", wait_eff, 3);
    tick(); rng = 3; @(negedge clk); check("R8 auto range3", wait_eff, 4);
    tick();
    access("R8 auto access latency", 4);
    dbg = 1; @(negedge clk); check("R9 debug zero wait", wait_eff, 0);
    tick();
    access("R9 debug access latency", 0);
    dbg = 0;

    cfg_write(0, 2, 0, 1, 0);
    viol = 1; tick(); viol = 0;
    @(negedge clk);
    check("R4 flag set", err_flag, 1);
    check("R4 flush pulse", flush, 1);
    check("R4 max wait", wait_eff, 15);
    check("R5 write blocked", wr_en, 0);
    check("R7 nmi raised", nmi, 1);
    tick(); @(negedge clk); check("R4 flush one cycle", flush, 0);
    tick(); dbg = 1; @(negedge clk); check("R9 debug overrides lockout", wait_eff, 0);
    tick(); dbg = 0;
    access("R4 lockout access latency", 15);

    cfg_write(0, 7, 0, 1, 0);
    @(negedge clk);
    check("R11 write without clear keeps flag", err_flag, 1);
    check("R6 lockout holds max wait", wait_eff, 15);
    tick();
    viol = 1; cfg_write(0, 7, 0, 1, 1); viol = 0;
    @(negedge clk);
    check("R10 clear with violation keeps flag", err_flag, 1);
    tick();
    cfg_write(0, 7, 0, 1, 1);
    @(negedge clk);
    check("R11 clear drops flag", err_flag, 0);
    check("R6 stored wait returns", wait_eff, 7);
    check("R5 write re-enabled", wr_en, 1);
    check("R7 nmi drops", nmi, 0);
    tick();

    cfg_write(0, 1, 1, 0, 0);
    viol = 1; tick(); viol = 0;
    @(negedge clk);
    check("R7 no nmi when disabled", nmi, 0);
    tick();
    cfg_write(0, 1, 1, 0, 1);
    @(negedge clk);
    check("R5 protected stays blocked", wr_en, 0);
    check("R6 wait 1 after clear", wait_eff, 1);
    tick();
    access("R3 one-wait latency", 1);
    repeat (2) tick();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule